// File: doc/BRIEF.md
# Beam capture interrupt and FIFO access controller

This block sits on a beam-position digitiser card, between the ADC capture path, a host register bus and one interrupt line. The capture path marks the start of a shot with `cap_start` and pulses `turn_inc` once for every turn it writes into the sample FIFO. The block counts those turns and keeps a write-active flag. When the shot closes, it freezes the count in a readable register and raises `irq` until the host acknowledges it. Host reads of the FIFO pass through this block. A read that arrives while capture is still writing is refused and answered with a bus error.

Two sources can close a shot. In normal mode, the ready strobe from the ADC clock module closes it. That strobe is not reliable on every shot, so a master mode is also provided. In master mode the ready strobe is ignored. The accepted machine trigger starts a timer that raises a NO_BEAM interrupt after 20.5 µs (2050 cycles of the 100 MHz clock) plus a programmable extra delay, so one card can start readout of a whole crate. Both asynchronous inputs go through a two-flop synchroniser and then a minimum-high-time filter, which rejects short glitches.

A turn count of zero tells the host that the shot carries no valid data. A nonzero count means the FIFO holds that many turns.

Top module: `bpm_irq_ctrl`

## Requirements
- R1: After reset `irq` and `fifo_bus_err` are 0, and the control register (address 0), the status register (address 1) and the turn register (address 2) all read 0.
- R2: In normal mode (control bit 0 = 0), `ready_in` held high for at least N consecutive clocks raises `irq` at the (N+2)-th rising edge, counted from the first edge that samples `ready_in` high. N is control bits [11:8], and a value of 0 is treated as 1. Status bit 1 (cause ready) then reads 1.
- R3: A high pulse on `ready_in` of fewer than N clocks raises no interrupt, and while no accepted ready strobe arrives `irq` stays low.
- R4: While write-active is set, a `fifo_rd_req` keeps `fifo_rd_en` low in that cycle, and `fifo_bus_err` is 1 in the cycle after it. Otherwise `fifo_rd_en` follows `fifo_rd_req` in the same cycle and no bus error is raised.
- R5: The turn register (address 2) holds the number of `turn_inc` pulses that arrived between `cap_start` and the closing of the shot. It reads 0 when no capture took place since the last acknowledge.
- R6: In master mode (control bit 0 = 1), a `trig_in` accepted by the same filter raises `irq` at edge N+2+2050+E, where E is control bits [31:16]. Status bit 2 (cause NO_BEAM) then reads 1.
- R7: In master mode `ready_in` raises no interrupt, and in normal mode `trig_in` raises none.
- R8: `irq` stays high until the host writes 1 to bit 0 of address 3, and it is low after that write. While it is high, triggers, ready strobes, `cap_start` and `turn_inc` change neither the status register nor the turn register.
- R9: Write-active (status bit 3) reads 1 from the edge that samples `cap_start` and returns to 0 when the shot closes.
- R10: The status register reads irq in bit 0, the cause in bits [2:1], write-active in bit 3, the master enable in bit 4, N in bits [11:8] and E in bits [31:16]. Exactly one cause bit is set while `irq` is high, and none is set while it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ready_in | input | 1 | Asynchronous ready strobe from the ADC clock module |
| trig_in | input | 1 | Asynchronous machine trigger |
| cap_start | input | 1 | One-cycle pulse from the capture path: a shot begins |
| turn_inc | input | 1 | One-cycle pulse from the capture path: one turn written to the FIFO |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 turns, 3 acknowledge) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| fifo_rd_req | input | 1 | Host request to read one FIFO word |
| fifo_rd_en | output | 1 | Read enable passed on to the FIFO |
| fifo_bus_err | output | 1 | Bus error for a refused FIFO read, one cycle after the request |
| irq | output | 1 | Host interrupt request |

## Verification
Shots are driven in both modes with random filter lengths, extra delays and turn counts. The exact interrupt latency separates a correct filter and timer from ones that are off by a cycle. Ready pulses one clock shorter than the filter length, and exactly as long as it, pin down where acceptance starts. Feeding ready to a master-mode card and a trigger to a normal-mode card shows that the mode selects the closing source. FIFO reads are issued both during capture and after it closes, and triggers, ready strobes and turn pulses are injected while the interrupt is pending, to show that the frozen turn count and cause survive until the acknowledge.

// File: rtl/bpm_irq_pkg.sv
// Package: shared types for the beam capture interrupt controller.
// Assumes a 32-bit register bus with a 2-bit word address.
package bpm_irq_pkg;

    localparam int DATA_W = 32;

    // Register word addresses seen by the host.
    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_TURN = 2'd2,
        ADDR_ACK  = 2'd3
    } reg_addr_e;

    // Interrupt cause; the encoding lands directly in status bits [2:1].
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_READY  = 2'b01,
        CAUSE_NOBEAM = 2'b10
    } cause_e;

endpackage

// File: rtl/bpm_irq_filt.sv
// Module: two-flop synchroniser followed by a minimum-high-time filter.
// Produces a single-cycle accept pulse in the cycle in which the
// synchronised input has been high for min_high consecutive clocks
// (a value of 0 counts as 1). Assumes din is asynchronous to clk.
module bpm_irq_filt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [CNT_W-1:0] min_high,
    output logic             acc
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] thr;

    // Bring the asynchronous input into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], din};
    end

    // Count consecutive high samples, saturating, and clear on a low sample.
    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= '0;
        else if (!sync_q[1])   run_q <= '0;
        else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
    end

    // Threshold with zero promoted to one; accept exactly once per high run.
    always_comb begin
        thr = (min_high == '0) ? CNT_W'(1) : min_high;
        acc = sync_q[1] && (run_q == thr - 1'b1);
    end

endmodule

// File: rtl/bpm_irq_delay.sv
// Module: NO_BEAM timer. A start pulse loads BASE + extra - 1, and fire is
// high in the last busy cycle, so the edge that follows fire lies exactly
// BASE + extra edges after the edge that took the start pulse.
// Assumes start is ignored while busy.
module bpm_irq_delay #(
    parameter int BASE    = 2050,
    parameter int EXTRA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [EXTRA_W-1:0] extra,
    output logic               busy,
    output logic               fire
);

    localparam int CNT_W = $clog2(BASE + (1 << EXTRA_W)) + 1;

    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to zero and drop busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(BASE) + CNT_W'(extra) - 1'b1;
        end
    end

    // Terminal count of the running timer.
    always_comb fire = busy && (cnt_q == '0);

endmodule

// File: rtl/bpm_irq_regs.sv
// Module: host register file. Holds the control word, decodes the
// acknowledge write and multiplexes read data. Reads are combinational on
// reg_addr. Assumes EXTRA_W <= 16 and FILT_W <= 8.
module bpm_irq_regs import bpm_irq_pkg::*; #(
    parameter int FILT_W  = 4,
    parameter int EXTRA_W = 16,
    parameter int TURN_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               irq,
    input  cause_e             cause,
    input  logic               wact,
    input  logic [TURN_W-1:0]  turns,
    output logic               master_en,
    output logic [FILT_W-1:0]  filt_len,
    output logic [EXTRA_W-1:0] extra_dly,
    output logic               ack
);

    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] stat_word;

    // Control register: master enable, filter length and extra delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_en <= 1'b0;
            filt_len  <= '0;
            extra_dly <= '0;
        end else if (reg_wr && reg_addr == ADDR_CTRL) begin
            master_en <= reg_wdata[0];
            filt_len  <= reg_wdata[8 +: FILT_W];
            extra_dly <= reg_wdata[16 +: EXTRA_W];
        end
    end

    // Acknowledge strobe: a write of 1 to bit 0 of the acknowledge address.
    always_comb ack = reg_wr && (reg_addr == ADDR_ACK) && reg_wdata[0];

    // Assemble the control and status words.
    always_comb begin
        ctrl_word               = '0;
        ctrl_word[0]            = master_en;
        ctrl_word[8 +: FILT_W]  = filt_len;
        ctrl_word[16 +: EXTRA_W] = extra_dly;
        stat_word               = ctrl_word;
        stat_word[0]            = irq;
        stat_word[2:1]          = cause;
        stat_word[3]            = wact;
        stat_word[4]            = master_en;
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_word;
            ADDR_STAT: reg_rdata = stat_word;
            ADDR_TURN: reg_rdata[TURN_W-1:0] = turns;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bpm_irq_ctrl.sv
// Module: beam capture interrupt and FIFO access controller (top).
// Filters the ready and trigger inputs, closes a shot either on ready
// (normal mode) or on the NO_BEAM timer (master mode), latches the turn
// count, holds the interrupt until acknowledged and gates host FIFO reads
// against an active capture. Assumes cap_start and turn_inc are
// synchronous one-cycle pulses from the capture path.
module bpm_irq_ctrl import bpm_irq_pkg::*; #(
    parameter int CLK_MHZ   = 100,
    parameter int NOBEAM_NS = 20500,
    parameter int FILT_W    = 4,
    parameter int EXTRA_W   = 16,
    parameter int TURN_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_in,
    input  logic              trig_in,
    input  logic              cap_start,
    input  logic              turn_inc,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fifo_rd_req,
    output logic              fifo_rd_en,
    output logic              fifo_bus_err,
    output logic              irq
);

    localparam int BASE_CYC = CLK_MHZ * NOBEAM_NS / 1000;
    localparam int N_IN     = 2;
    localparam int IDX_RDY  = 0;
    localparam int IDX_TRIG = 1;
    localparam logic [TURN_W-1:0] TURN_MAX = '1;

    logic               master_en;
    logic [FILT_W-1:0]  filt_len;
    logic [EXTRA_W-1:0] extra_dly;
    logic               ack;
    logic [N_IN-1:0]    raw_in;
    logic [N_IN-1:0]    acc;
    logic               dly_busy;
    logic               dly_fire;
    logic               trig_start;
    logic               rdy_evt;
    logic               nb_evt;
    logic               pend;
    cause_e             cause;
    logic               wact;
    logic [TURN_W-1:0]  run_cnt;
    logic [TURN_W-1:0]  turn_q;
    logic               bus_err_q;

    // Gather the asynchronous inputs in filter order.
    always_comb begin
        raw_in[IDX_RDY]  = ready_in;
        raw_in[IDX_TRIG] = trig_in;
    end

    // One synchroniser and glitch filter per asynchronous input.
    for (genvar g = 0; g < N_IN; g++) begin : g_filt
        bpm_irq_filt #(
            .CNT_W (FILT_W)
        ) i_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (raw_in[g]),
            .min_high (filt_len),
            .acc      (acc[g])
        );
    end

    // Qualify the shot-closing events against mode and pending state.
    always_comb begin
        trig_start = acc[IDX_TRIG] && master_en && !pend && !dly_busy;
        rdy_evt    = acc[IDX_RDY] && !master_en && !pend;
        nb_evt     = dly_fire && !pend;
    end

    bpm_irq_delay #(
        .BASE    (BASE_CYC),
        .EXTRA_W (EXTRA_W)
    ) i_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .start (trig_start),
        .extra (extra_dly),
        .busy  (dly_busy),
        .fire  (dly_fire)
    );

    // Shot state: capture tracking, count latch, interrupt and cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            cause   <= CAUSE_NONE;
            wact    <= 1'b0;
            run_cnt <= '0;
            turn_q  <= '0;
        end else if (pend) begin
            if (ack) begin
                pend    <= 1'b0;
                cause   <= CAUSE_NONE;
                run_cnt <= '0;
            end
        end else if (rdy_evt || nb_evt) begin
            pend   <= 1'b1;
            cause  <= rdy_evt ? CAUSE_READY : CAUSE_NOBEAM;
            turn_q <= run_cnt;
            wact   <= 1'b0;
        end else if (cap_start) begin
            wact    <= 1'b1;
            run_cnt <= '0;
        end else if (wact && turn_inc && run_cnt != TURN_MAX) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Refused FIFO reads produce a bus error one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err_q <= 1'b0;
        else        bus_err_q <= fifo_rd_req && wact;
    end

    // FIFO read enable passes through only when capture is idle.
    always_comb begin
        fifo_rd_en   = fifo_rd_req && !wact;
        fifo_bus_err = bus_err_q;
        irq          = pend;
    end

    bpm_irq_regs #(
        .FILT_W  (FILT_W),
        .EXTRA_W (EXTRA_W),
        .TURN_W  (TURN_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (pend),
        .cause     (cause),
        .wact      (wact),
        .turns     (turn_q),
        .master_en (master_en),
        .filt_len  (filt_len),
        .extra_dly (extra_dly),
        .ack       (ack)
    );

endmodule

// File: rtl/bpm_irq_ctrl_chk.sv
// Module: property checker for bpm_irq_ctrl, attached with bind.
// Observes ports plus the shot state registers of the top.
module bpm_irq_ctrl_chk #(
    parameter int TURN_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              fifo_rd_req,
    input logic              fifo_rd_en,
    input logic              fifo_bus_err,
    input logic              wact,
    input logic [1:0]        cause,
    input logic [TURN_W-1:0] turn_q
);

    logic ack_wr;

    // Acknowledge write as seen on the bus ports.
    always_comb ack_wr = reg_wr && (reg_addr == 2'd3) && reg_wdata[0];

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) irq && !ack_wr |=> irq); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) irq && ack_wr |=> !irq); // R8
    AST_TURNS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) irq && $past(irq) |-> $stable(turn_q)); // R8
    AST_BUSERR_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n) fifo_rd_req && wact |=> fifo_bus_err); // R4
    AST_NO_DATA_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n) fifo_bus_err |-> $past(fifo_rd_req) && !$past(fifo_rd_en)); // R4
    AST_CAPTURE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> !wact); // R9
    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $countones(cause) == 1); // R10
    AST_NO_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !irq |-> cause == 2'b00); // R10

endmodule

bind bpm_irq_ctrl bpm_irq_ctrl_chk #(
    .TURN_W (TURN_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq          (irq),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .fifo_rd_req  (fifo_rd_req),
    .fifo_rd_en   (fifo_rd_en),
    .fifo_bus_err (fifo_bus_err),
    .wact         (wact),
    .cause        (cause),
    .turn_q       (turn_q)
);

// File: tb/test_bpm_irq_ctrl.sv
// Bench: seeded random shots in both modes plus directed corner cases.
module test_bpm_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 2050;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ready_in, trig_in, cap_start, turn_inc;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        fifo_rd_req, fifo_rd_en, fifo_bus_err, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bpm_irq_ctrl i_bpm_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ready_in(ready_in), .trig_in(trig_in),
        .cap_start(cap_start), .turn_inc(turn_inc), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_rd_req(fifo_rd_req), .fifo_rd_en(fifo_rd_en),
        .fifo_bus_err(fifo_bus_err), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected edge count from first high sample to irq.
    function automatic int exp_lat(bit master, int n, int extra);
        return n + 2 + (master ? BASE + extra : 0);
    endfunction

    // Expected status word from the field layout of R10.
    function automatic logic [31:0] exp_stat(bit pend, bit master, bit wact, int n, int extra);
        logic [31:0] w;
        w = '0;
        w[0] = pend;
        w[1] = pend && !master;
        w[2] = pend && master;
        w[3] = wact;
        w[4] = master;
        w[11:8] = 4'(n);
        w[31:16] = 16'(extra);
        return w;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic set_ctrl(bit master, int n, int extra);
        wr(2'd0, {16'(extra), 4'b0, 4'(n), 7'b0, master});
    endtask

    // Raise the selected inputs, drop them after hold edges, count edges to irq.
    task automatic measure(bit use_rdy, bit use_trig, int hold, int limit, output int cnt);
        ready_in = use_rdy; trig_in = use_trig;
        cnt = 0;
        for (int i = 0; i < limit; i++) begin
            tick();
            cnt++;
            if (cnt == hold) begin ready_in = 1'b0; trig_in = 1'b0; end
            if (irq) break;
        end
        ready_in = 1'b0; trig_in = 1'b0;
    endtask

    task automatic shot(bit master, int n, int extra, int turns, bit rd_busy);
        logic [31:0] v;
        int cnt;
        set_ctrl(master, n, extra);
        cap_start = 1'b1; tick(); cap_start = 1'b0;
        rd(2'd1, v);
        chk("R9", "write-active after cap_start", v[3], 1);
        for (int i = 0; i < turns; i++) begin
            turn_inc = 1'b1;
            if (rd_busy && i == 0) begin
                fifo_rd_req = 1'b1;
                #1;
                chk("R4", "rd_en during capture", fifo_rd_en, 0);
            end
            tick();
            turn_inc = 1'b0;
            if (rd_busy && i == 0) begin
                fifo_rd_req = 1'b0;
                chk("R4", "bus error during capture", fifo_bus_err, 1);
            end
            tick();
        end
        measure(1'b1, master, n + 3, BASE + 200 + extra, cnt);
        chk(master ? "R6" : "R2", "irq latency", cnt, exp_lat(master, n, extra));
        rd(2'd1, v);
        chk("R10", "status after close", v, exp_stat(1, master, 0, n, extra));
        rd(2'd2, v);
        chk("R5", "turn count", v, turns);
        fifo_rd_req = 1'b1;
        #1;
        chk("R4", "rd_en when idle", fifo_rd_en, 1);
        tick();
        fifo_rd_req = 1'b0;
        chk("R4", "no bus error when idle", fifo_bus_err, 0);
        // Stimulus while pending must change nothing.
        cap_start = 1'b1; tick(); cap_start = 1'b0;
        turn_inc = 1'b1; tick(); turn_inc = 1'b0;
        ready_in = 1'b1; trig_in = 1'b1;
        repeat (n + 3) tick();
        ready_in = 1'b0; trig_in = 1'b0;
        repeat (4) tick();
        chk("R8", "irq held while pending", irq, 1);
        rd(2'd1, v);
        chk("R8", "status frozen while pending", v, exp_stat(1, master, 0, n, extra));
        rd(2'd2, v);
        chk("R8", "turns frozen while pending", v, turns);
        wr(2'd3, 32'd1);
        chk("R8", "irq cleared by ack", irq, 0);
        rd(2'd1, v);
        chk("R10", "status after ack", v, exp_stat(0, master, 0, n, extra));
        repeat (3) tick();
    endtask

    initial begin
        logic [31:0] v;
        int cnt;
        void'($urandom(32'h5EED_0B3A));
        rst_n = 1'b0;
        ready_in = 0; trig_in = 0; cap_start = 0; turn_inc = 0;
        reg_wr = 0; reg_addr = 0; reg_wdata = 0; fifo_rd_req = 0;
        repeat (5) tick();
        rst_n = 1'b1;
        tick();
        chk("R1", "irq after reset", irq, 0);
        chk("R1", "bus error after reset", fifo_bus_err, 0);
        rd(2'd0, v); chk("R1", "control after reset", v, 0);
        rd(2'd1, v); chk("R1", "status after reset", v, 0);
        rd(2'd2, v); chk("R1", "turns after reset", v, 0);

        // R3: ready one clock short of the filter length is rejected.
        set_ctrl(0, 4, 0);
        cap_start = 1'b1; tick(); cap_start = 1'b0;
        ready_in = 1'b1; repeat (3) tick(); ready_in = 1'b0;
        repeat (20) tick();
        chk("R3", "short ready pulse", irq, 0);
        // R2: ready held exactly N clocks is accepted.
        measure(1'b1, 1'b0, 4, 50, cnt);
        chk("R2", "ready of exactly N clocks latency", cnt, exp_lat(0, 4, 0));
        rd(2'd2, v); chk("R5", "turns with no turn pulses", v, 0);
        wr(2'd3, 32'd1);
        repeat (3) tick();

        // R7: trigger in normal mode raises nothing.
        set_ctrl(0, 1, 0);
        trig_in = 1'b1; repeat (5) tick(); trig_in = 1'b0;
        repeat (40) tick();
        chk("R7", "trigger in normal mode", irq, 0);
        // R7: ready in master mode raises nothing, even past the timeout.
        set_ctrl(1, 1, 0);
        ready_in = 1'b1; repeat (5) tick(); ready_in = 1'b0;
        repeat (BASE + 50) tick();
        chk("R7", "ready in master mode", irq, 0);

        // Directed boundaries, then seeded random shots.
        shot(0, 1, 0, 0, 0);
        shot(1, 1, 0, 3, 1);
        shot(1, 15, 37, 5, 0);
        for (int s = 0; s < 12; s++) begin
            shot(1'($urandom % 2), 1 + int'($urandom % 5), int'($urandom % 40),
                 int'($urandom % 13), 1'($urandom % 2));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule